// File: doc/BRIEF.md
# Fixed-Timeout Hardware Watchdog

This block is an always-on watchdog clocked by the 32768 Hz real-time-clock time base. Firmware must pulse a refresh strobe often enough to keep a free-running cycle count below a fixed limit. The default limit is 49152 cycles, or 1.5 s. If the count reaches the limit, the block raises a one-cycle system reset, as an external reset would. It then holds the processor-start enable low for a fixed release delay. The default delay is 4100 cycles, about 125 ms. When the enable rises, the processor fetches from address zero.

No register bit can turn the watchdog off. Only two hardware inputs can stop it: the debug-enable input, and a board strap tied to the supply. The strap has no effect in brownout mode, where only debug-enable works. A low wake signal keeps the count at zero.

A sticky status flag records that an overflow happened. Firmware clears it with a clear strobe. The external reset pin also clears it, and so does being in sleep mode. The flag is kept through the watchdog's own reset and through LCD mode.

Top module: `rtc_watchdog`

## Requirements
- R1: With the watchdog active, wake high and no refresh, the system reset output goes high for exactly one cycle. This happens at the TIMEOUT-th clock edge after the count last started from zero (TIMEOUT defaults to 49152).
- R2: A high refresh input clears the count, and a low refresh input leaves it alone. If the refresh arrives in the cycle that would otherwise overflow, the refresh wins and no reset is produced.
- R3: While wake is low, the count is held at zero and no overflow can occur.
- R4: While the debug-enable input is high, the watchdog is inactive in every power mode.
- R5: The disable strap makes the watchdog inactive in every power mode except brownout. The power-mode encoding is 00 normal, 01 brownout, 10 LCD and 11 sleep. In brownout the strap is ignored and the watchdog still overflows.
- R6: The processor-start enable falls in the same cycle as the overflow reset pulse. It stays low for exactly RELEASE cycles (default 4100) and then rises. Counting restarts from zero once it rises.
- R7: An overflow sets the status flag in the cycle of the reset pulse. The flag stays set through the release delay and through LCD mode.
- R8: The flag is cleared one edge after a high clear strobe, or one edge after the power mode reads sleep (11). If an overflow happens in the same cycle as a clear request, the overflow sets the flag and it stays set.
- R9: The synchronous reset pin leaves the system reset low, the processor-start enable high and the status flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Real-time-clock time base |
| rst_i | input | 1 | External reset pin, synchronous, active high |
| kick_i | input | 1 | Firmware refresh strobe, high restarts the count |
| wake_i | input | 1 | Wake signal, low holds the count at zero |
| dbg_en_i | input | 1 | Debug enable, high deactivates the watchdog |
| strap_dis_i | input | 1 | Board disable strap (ignored in brownout) |
| flag_clr_i | input | 1 | Firmware clear of the status flag |
| pwr_mode_i | input | 2 | Power mode: 00 normal, 01 brownout, 10 LCD, 11 sleep |
| wdt_rst_o | output | 1 | One-cycle system reset on overflow |
| cpu_en_o | output | 1 | Processor start enable, low during the release delay |
| ovf_flag_o | output | 1 | Sticky overflow status flag |

## Verification
A count register stuck or cleared at the wrong moment shows up as a reset pulse on the wrong edge. This becomes visible no later than one timeout window after the fault. A release counter with the wrong bound changes the length of the processor-start low time. The mismatch appears at the very first release after an overflow. A faulty flag path shows within one edge of an overflow, a clear strobe or sleep entry. The bench therefore runs a behavioural model alongside the block and compares every output on every cycle. Directed checks cover the exact overflow edge, the release length, and the refresh-wins, strap-in-brownout and set-over-clear cases.

// File: rtl/rtc_wdt_pkg.sv
package rtc_wdt_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_BROWN  = 2'b01,
    PM_LCD    = 2'b10,
    PM_SLEEP  = 2'b11
  } pmode_t;
endpackage

// File: rtl/wdt_gate.sv
// Decides whether the watchdog is allowed to count this cycle.
module wdt_gate
  import rtc_wdt_pkg::*;
(
  input  logic       dbg_en_i,
  input  logic       strap_dis_i,
  input  logic [1:0] pwr_mode_i,
  output logic       active_o
);
  pmode_t mode;
  logic   strap_ok;

  always_comb begin
    mode     = pmode_t'(pwr_mode_i);
    // the board strap only works while the supply is good
    strap_ok = strap_dis_i && (mode != PM_BROWN);
    active_o = !dbg_en_i && !strap_ok;
  end
endmodule

// File: rtl/wdt_span.sv
// Timeout counter: counts time-base cycles since the last refresh.
module wdt_span #(
  parameter int TIMEOUT = 49152
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic active_i,
  input  logic wake_i,
  input  logic kick_i,
  input  logic hold_i,
  output logic trip_o
);
  localparam int CW = $clog2(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;
  logic          restart;

  always_comb begin
    restart = hold_i || !active_i || !wake_i || kick_i;
    // a refresh in the final cycle suppresses the trip
    trip_o  = !restart && (cnt == LAST);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt <= '0;
    end else if (restart || trip_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_release.sv
// Emits the reset pulse and holds the processor off for RELEASE cycles.
module wdt_release #(
  parameter int RELEASE = 4100
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trip_i,
  output logic wdt_rst_o,
  output logic cpu_en_o
);
  localparam int HW = $clog2(RELEASE);
  localparam logic [HW-1:0] HLAST = HW'(RELEASE - 1);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wdt_rst_o <= 1'b0;
      cpu_en_o  <= 1'b1;
      hcnt      <= '0;
    end else begin
      wdt_rst_o <= trip_i;
      if (trip_i) begin
        cpu_en_o <= 1'b0;
        hcnt     <= '0;
      end else if (!cpu_en_o) begin
        if (hcnt == HLAST) begin
          cpu_en_o <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_flag.sv
// Sticky overflow status; a set always beats a clear in the same cycle.
module wdt_flag
  import rtc_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       trip_i,
  input  logic       flag_clr_i,
  input  logic [1:0] pwr_mode_i,
  output logic       flag_o
);
  logic drop;

  always_comb drop = flag_clr_i || (pmode_t'(pwr_mode_i) == PM_SLEEP);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_o <= 1'b0;
    end else if (trip_i) begin
      flag_o <= 1'b1;
    end else if (drop) begin
      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog #(
  parameter int TIMEOUT = 49152,
  parameter int RELEASE = 4100
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       kick_i,
  input  logic       wake_i,
  input  logic       dbg_en_i,
  input  logic       strap_dis_i,
  input  logic       flag_clr_i,
  input  logic [1:0] pwr_mode_i,
  output logic       wdt_rst_o,
  output logic       cpu_en_o,
  output logic       ovf_flag_o
);
  logic active;
  logic trip;
  logic hold;

  assign hold = !cpu_en_o;

  wdt_gate u_gate (
    .dbg_en_i    (dbg_en_i),
    .strap_dis_i (strap_dis_i),
    .pwr_mode_i  (pwr_mode_i),
    .active_o    (active)
  );

  wdt_span #(.TIMEOUT(TIMEOUT)) u_span (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .active_i (active),
    .wake_i   (wake_i),
    .kick_i   (kick_i),
    .hold_i   (hold),
    .trip_o   (trip)
  );

  wdt_release #(.RELEASE(RELEASE)) u_rel (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .trip_i    (trip),
    .wdt_rst_o (wdt_rst_o),
    .cpu_en_o  (cpu_en_o)
  );

  wdt_flag u_flag (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .trip_i     (trip),
    .flag_clr_i (flag_clr_i),
    .pwr_mode_i (pwr_mode_i),
    .flag_o     (ovf_flag_o)
  );
endmodule

// File: rtl/rtc_watchdog_chk.sv
module rtc_watchdog_chk #(
  parameter int RELEASE = 4100
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       kick_i,
  input logic       wake_i,
  input logic       dbg_en_i,
  input logic       strap_dis_i,
  input logic       flag_clr_i,
  input logic [1:0] pwr_mode_i,
  input logic       wdt_rst_o,
  input logic       cpu_en_o,
  input logic       ovf_flag_o
);
  int lowc;

  always_ff @(posedge clk_i) begin
    if (rst_i) lowc <= 0;
    else if (!cpu_en_o) lowc <= lowc + 1;
    else lowc <= 0;
  end

  p_pulse_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_rst_o |=> !wdt_rst_o);
  p_kick_wins_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    kick_i |=> !wdt_rst_o);
  p_wake_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !wake_i |=> !wdt_rst_o);
  p_debug_off_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    dbg_en_i |=> !wdt_rst_o);
  p_strap_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (strap_dis_i && pwr_mode_i != 2'b01) |=> !wdt_rst_o);
  p_release_len_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cpu_en_o) |-> (lowc == RELEASE));
  p_set_on_ovf_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_rst_o |-> (ovf_flag_o && !cpu_en_o));
  p_flag_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_flag_o && !flag_clr_i && pwr_mode_i != 2'b11) |=> ovf_flag_o);
  p_clr_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_clr_i || pwr_mode_i == 2'b11) |=> (!ovf_flag_o || wdt_rst_o));
endmodule

bind rtc_watchdog rtc_watchdog_chk #(.RELEASE(RELEASE)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .kick_i      (kick_i),
  .wake_i      (wake_i),
  .dbg_en_i    (dbg_en_i),
  .strap_dis_i (strap_dis_i),
  .flag_clr_i  (flag_clr_i),
  .pwr_mode_i  (pwr_mode_i),
  .wdt_rst_o   (wdt_rst_o),
  .cpu_en_o    (cpu_en_o),
  .ovf_flag_o  (ovf_flag_o)
);

// File: tb/sim_rtc_watchdog.sv
`timescale 1ns/1ps
module sim_rtc_watchdog;
  localparam int T = 64;
  localparam int R = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b0, wake = 1'b1, dbg = 1'b0, strap = 1'b0, clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wdt_rst, cpu_en, flag;

  int checks = 0, fails = 0, cycles = 0;
  bit cmp_on = 1'b0;
  bit seen_rst = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  int m_cnt = 0, m_hold = 0;
  bit m_rst = 1'b0, m_en = 1'b1, m_flag = 1'b0;

  always #2 clk = ~clk;

  rtc_watchdog #(.TIMEOUT(T), .RELEASE(R)) u0 (
    .clk_i(clk), .rst_i(rst), .kick_i(kick), .wake_i(wake),
    .dbg_en_i(dbg), .strap_dis_i(strap), .flag_clr_i(clr),
    .pwr_mode_i(mode), .wdt_rst_o(wdt_rst), .cpu_en_o(cpu_en),
    .ovf_flag_o(flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit ov, enabled;
    cycles++;
    ov = 1'b0;
    if (rst) begin
      m_cnt = 0; m_hold = 0; m_rst = 1'b0; m_en = 1'b1; m_flag = 1'b0;
    end else begin
      m_rst = 1'b0;
      if (m_hold > 0) begin
        m_hold--;
        if (m_hold == 0) m_en = 1'b1;
        m_cnt = 0;
      end else begin
        enabled = !dbg && !(strap && mode != 2'b01);
        if (!enabled || !wake || kick) m_cnt = 0;
        else if (m_cnt == T - 1) begin
          ov = 1'b1; m_cnt = 0; m_rst = 1'b1; m_en = 1'b0; m_hold = R;
        end else m_cnt++;
      end
      if (ov) m_flag = 1'b1;
      else if (clr || mode == 2'b11) m_flag = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 model reset pulse", wdt_rst, m_rst);
      chk("R6 model start enable", cpu_en, m_en);
      chk("R7 model status flag", flag, m_flag);
    end
    if (wdt_rst === 1'b1) seen_rst = 1'b1;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ovf(output int n);
    n = 0;
    do begin
      cyc(1); n++;
    end while (wdt_rst !== 1'b1 && n < 4 * T);
  endtask

  task automatic wait_release();
    int k = 0;
    while (cpu_en !== 1'b1 && k < 4 * R) begin cyc(1); k++; end
  endtask

  initial begin
    int n;
    int low;
    cyc(3);
    cmp_on = 1'b1;
    // R9 reset state
    chk("R9 reset pulse low", wdt_rst, 0);
    chk("R9 start enable high", cpu_en, 1);
    chk("R9 flag low", flag, 0);
    rst = 1'b0;

    // R1 exact overflow edge
    wait_ovf(n);
    chk("R1 overflow edge", n, T);
    chk("R7 flag set with pulse", flag, 1);
    chk("R6 enable low with pulse", cpu_en, 0);
    cyc(1);
    chk("R1 pulse one cycle", wdt_rst, 0);

    // R6 release length
    low = 1;
    while (cpu_en !== 1'b1 && low < 4 * R) begin
      if (cpu_en === 1'b0) low++;
      cyc(1);
    end
    chk("R6 release length", low, R);
    mode = 2'b10;
    kick = 1'b1;
    cyc(T / 2);
    chk("R7 flag kept in LCD mode", flag, 1);

    // R8 firmware clear
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R8 clear strobe", flag, 0);

    // R2 refresh exactly at the last cycle
    seen_rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      kick = 1'b1; cyc(1); kick = 1'b0; cyc(T - 1);
    end
    kick = 1'b1; cyc(1); kick = 1'b0;
    chk("R2 refresh wins, no overflow", seen_rst, 0);

    // R3 wake low clears
    seen_rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      wake = 1'b0; cyc(1); wake = 1'b1; cyc(T - 1);
    end
    wake = 1'b0; cyc(1); wake = 1'b1;
    chk("R3 wake low holds count", seen_rst, 0);

    // R4 debug disable in brownout
    seen_rst = 1'b0;
    mode = 2'b01; dbg = 1'b1;
    cyc(3 * T);
    chk("R4 debug disables", seen_rst, 0);
    dbg = 1'b0; mode = 2'b00;

    // R5 strap disables in normal mode
    seen_rst = 1'b0;
    strap = 1'b1;
    cyc(3 * T);
    chk("R5 strap disables in normal mode", seen_rst, 0);
    mode = 2'b01;
    wait_ovf(n);
    chk("R5 strap ignored in brownout", n, T);
    wait_release();
    strap = 1'b0;
    chk("R7 flag kept after release", flag, 1);

    // R8 sleep clears
    mode = 2'b11; cyc(1);
    chk("R8 sleep clears flag", flag, 0);
    mode = 2'b00;

    // R8 set beats clear
    clr = 1'b1;
    wait_ovf(n);
    chk("R8 set wins over clear", flag, 1);
    cyc(1);
    chk("R8 clear after overflow cycle", flag, 0);
    clr = 1'b0;
    wait_release();

    // R9 pin reset clears the flag
    wait_ovf(n);
    chk("R7 flag set again", flag, 1);
    wait_release();
    rst = 1'b1; cyc(2);
    chk("R9 pin reset clears flag", flag, 0);
    chk("R9 start enable after reset", cpu_en, 1);
    rst = 1'b0; cyc(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule